// File: doc/BRIEF.md
# Two-Wire Status Byte Slave

This block is a slave on a two-wire serial bus (SMBus read-byte protocol) through which an external microcontroller reads one byte of platform status. The master first writes a one-byte command selecting what to read. It then issues a repeated start, addresses the slave again with the read bit set, and clocks out a single byte. The master ends with a not-acknowledge and a stop condition.

The slave answers only to the 7-bit address presented on its `own_addr` input. The returned byte is assembled from live inputs: a 3-bit system power state, and a 10-bit watchdog count that saturates into a 6-bit field. The line inputs pass through a synchronizer and edge detector running on the system clock. The slave never drives the data line high. It only asserts `sda_drive_low`, which controls an external open-drain pull-down.

Top module: `smb_status_reader`

## Requirements
- R1: Out of reset the slave holds `sda_drive_low` at 0 and ignores bus activity until a start condition (SDA falling while SCL is high).
- R2: After a start, an address byte equal to {own_addr, 0}, sent MSB first, is acknowledged: SDA is held low while SCL is high in the ninth clock.
- R3: An address byte that differs from own_addr, or that carries the wrong read/write bit for its phase, is not acknowledged. The slave then ignores every further byte until the next start condition.
- R4: The command byte that follows an acknowledged write address is acknowledged whatever its value.
- R5: After a repeated start, an address byte equal to {own_addr, 1} is acknowledged. The slave then shifts the status byte out MSB first and changes SDA only while SCL is low.
- R6: Command 0x00 (capabilities), command 0x02, and every command other than 0x01 and 0x03 return 0x00.
- R7: Command 0x01 returns the power state in bits 2:0 (000 = S0, 011 = S3, 101 = S5; other codes pass through unchanged) and zeros in bits 7:3.
- R8: Command 0x03 returns min(watchdog count, 0x3F) in bits 5:0 and zeros in bits 7:6.
- R9: The data byte is captured from the status inputs when the second address byte completes. Changes to the inputs after that do not alter the byte being sent.
- R10: A start condition in the middle of a byte restarts address reception. A stop condition returns the slave to idle with SDA released. In both cases a following complete transaction reads correctly.
- R11: After the eighth data bit the slave releases SDA, so the master's not-acknowledge reads high, and SDA stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr | input | 7 | Programmable 7-bit slave address |
| power_state | input | 3 | Live system power state code |
| wdog_count | input | 10 | Live watchdog counter value |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 leaves it released |

## Verification
The hardest situations to reach are the aborts: a start or stop condition that arrives partway through a byte, after the slave has already accepted some bits. The bench master stops clocking after a chosen number of bits and issues the condition. It then runs a complete read at once, which shows that the stale bit count and phase were discarded. Capture timing (R9) is exercised by changing the power state between the read-address acknowledge and the first data bit. The bench then compares the received byte with the value held before the change.

// File: rtl/smb_status_pkg.sv
package smb_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_WAIT_RS,
    ST_TX,
    ST_DONE
  } bus_state_t;

  typedef enum logic [1:0] {
    STG_ADDR_WR,
    STG_CMD,
    STG_ADDR_RD
  } stage_t;

  localparam logic [7:0] CMD_CAPS  = 8'h00;
  localparam logic [7:0] CMD_POWER = 8'h01;
  localparam logic [7:0] CMD_WDOG  = 8'h03;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign rise   = line_s & ~prev;
  assign fall   = ~line_s & prev;
endmodule

// File: rtl/smb_status_mux.sv
module smb_status_mux
  import smb_status_pkg::*;
#(
  parameter int PWR_W   = 3,
  parameter int WD_W    = 10,
  parameter int FIELD_W = 6
) (
  input  logic [7:0]       cmd,
  input  logic [PWR_W-1:0] power_state,
  input  logic [WD_W-1:0]  wdog_count,
  output logic [7:0]       byte_out
);
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;

  function automatic logic [FIELD_W-1:0] clamp_count(input logic [WD_W-1:0] v);
    if (v > WD_W'(FIELD_MAX)) return FIELD_W'(FIELD_MAX);
    return v[FIELD_W-1:0];
  endfunction

  function automatic logic [7:0] pick_byte(input logic [7:0] c,
                                           input logic [PWR_W-1:0] p,
                                           input logic [WD_W-1:0] w);
    logic [7:0] r;
    r = '0;
    case (c)
      CMD_POWER: r[PWR_W-1:0]   = p;
      CMD_WDOG:  r[FIELD_W-1:0] = clamp_count(w);
      default:   r = '0;
    endcase
    return r;
  endfunction

  assign byte_out = pick_byte(cmd, power_state, wdog_count);
endmodule

// File: rtl/smb_status_reader.sv
module smb_status_reader
  import smb_status_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PWR_W       = 3,
  parameter int WD_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [PWR_W-1:0]  power_state,
  input  logic [WD_W-1:0]   wdog_count,
  output logic              sda_drive_low
);
  localparam int BYTE_W  = ADDR_W + 1;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int FIELD_W = 6;
  localparam int WD_SAT  = (1 << FIELD_W) - 1;

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in),
    .line_s(scl_s), .rise(scl_rise), .fall(scl_fall));

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in),
    .line_s(sda_s), .rise(sda_rise), .fall(sda_fall));

  // Named bus events
  logic start_det, stop_det;
  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;

  bus_state_t         state;
  stage_t             stage;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  rx_sh;
  logic [7:0]         cmd_q;
  logic [7:0]         tx_sh;
  logic [2:0]         tx_cnt;
  logic [7:0]         status_byte;

  smb_status_mux #(.PWR_W(PWR_W), .WD_W(WD_W), .FIELD_W(FIELD_W)) u_mux (
    .cmd(cmd_q), .power_state(power_state), .wdog_count(wdog_count),
    .byte_out(status_byte));

  logic byte_done, addr_phase, addr_ok, capture_ev;
  assign byte_done  = (state == ST_RX) && scl_fall && (bit_cnt == CNT_W'(BYTE_W))
                      && !start_det && !stop_det;
  assign addr_phase = (stage == STG_ADDR_WR) || (stage == STG_ADDR_RD);
  assign addr_ok    = (rx_sh == {own_addr, (stage == STG_ADDR_RD)});
  assign capture_ev = byte_done && (stage == STG_ADDR_RD) && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      stage         <= STG_ADDR_WR;
      bit_cnt       <= '0;
      rx_sh         <= '0;
      cmd_q         <= '0;
      tx_sh         <= '0;
      tx_cnt        <= '0;
      sda_drive_low <= 1'b0;
    end else if (stop_det) begin
      state         <= ST_IDLE;
      sda_drive_low <= 1'b0;
    end else if (start_det) begin
      state         <= ST_RX;
      stage         <= (state == ST_WAIT_RS) ? STG_ADDR_RD : STG_ADDR_WR;
      bit_cnt       <= '0;
      sda_drive_low <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (addr_phase && !addr_ok) begin
              state <= ST_IDLE;
            end else begin
              state         <= ST_ACK;
              sda_drive_low <= 1'b1;
              if (stage == STG_CMD) cmd_q <= rx_sh;
              if (capture_ev) tx_sh <= status_byte;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_drive_low <= 1'b0;
            case (stage)
              STG_ADDR_WR: begin
                state   <= ST_RX;
                stage   <= STG_CMD;
                bit_cnt <= '0;
              end
              STG_CMD: state <= ST_WAIT_RS;
              default: begin
                state         <= ST_TX;
                tx_cnt        <= '0;
                sda_drive_low <= ~tx_sh[7];
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (tx_cnt == 3'd7) begin
              state         <= ST_DONE;
              sda_drive_low <= 1'b0;
            end else begin
              tx_sh         <= {tx_sh[6:0], 1'b0};
              sda_drive_low <= ~tx_sh[6];
              tx_cnt        <= tx_cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Assertions
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive_low);

  p_ack_holds_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK) |-> sda_drive_low);

  p_nack_on_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && addr_phase && !addr_ok) |=> (state == ST_IDLE) && !sda_drive_low);

  p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);

  p_wdog_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_ev && cmd_q == CMD_WDOG && wdog_count > WD_W'(WD_SAT)) |=> (tx_sh == 8'h3F));

  p_restart_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX) && (bit_cnt == '0));

  p_idle_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_drive_low);

  p_release_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !sda_drive_low);
endmodule

// File: tb/smb_status_reader_test.sv
module smb_status_reader_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2C;
  logic [2:0] power_state = 3'b000;
  logic [9:0] wdog_count = '0;
  wire        sda_drive_low;
  wire        sda_bus = sda_m & ~sda_drive_low;

  int tests = 0;
  int fails = 0;
  int r5_viol = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  smb_status_reader uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .own_addr(own_addr), .power_state(power_state), .wdog_count(wdog_count),
    .sda_drive_low(sda_drive_low));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] c, input logic [2:0] p,
                                       input logic [9:0] w);
    if (c == 8'h01) return {5'b0, p};
    if (c == 8'h03) return (w >= 10'd64) ? 8'h3F : {2'b0, w[5:0]};
    return 8'h00;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); v = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = !a;
  endtask

  // Scoreboard driver: full read-byte transaction
  task automatic run_read(input logic [7:0] cmd, input bit flip, input string tag);
    bit k1, k2, k3;
    logic v;
    logic [7:0] d;
    exp_q.push_back(model(cmd, power_state, wdog_count));
    tag_q.push_back(tag);
    bus_start();
    put_byte({own_addr, 1'b0}, k1);
    check(k1, "R2 write address ack", k1, 1);
    put_byte(cmd, k2);
    check(k2, "R4 command ack", k2, 1);
    bus_start();
    put_byte({own_addr, 1'b1}, k3);
    check(k3, "R5 read address ack", k3, 1);
    if (flip) power_state = ~power_state;
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      d[i] = v;
    end
    get_bit(v);
    check(v == 1'b1, "R11 NACK bit reads high", v, 1);
    got_q.push_back(d);
    bus_stop();
    check(!sda_drive_low, "R11 released after stop", sda_drive_low, 0);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  // R5: slave-driven SDA may only move while SCL is low
  logic scl_prev = 1'b1;
  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_prev && scl_m && (drv_prev != sda_drive_low)) r5_viol++;
    scl_prev <= scl_m;
    drv_prev <= sda_drive_low;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit k;
    repeat (5) @(negedge clk);
    check(!sda_drive_low, "R1 released in reset", sda_drive_low, 0);
    rst_n = 1'b1;
    wq();
    check(!sda_drive_low, "R1 released after reset", sda_drive_low, 0);

    // R1: clocking without a start is ignored
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    check(!sda_drive_low, "R1 no start no ack", sda_drive_low, 0);
    sda_m = 1'b1; scl_m = 1'b1; wq();

    power_state = 3'b011; run_read(8'h01, 0, "R7 power S3");
    power_state = 3'b101; run_read(8'h01, 0, "R7 power S5");
    power_state = 3'b000; run_read(8'h01, 0, "R7 power S0");
    power_state = 3'b111; run_read(8'h01, 0, "R7 reserved code 111");

    wdog_count = 10'd37;   run_read(8'h03, 0, "R8 watchdog 37");
    wdog_count = 10'd63;   run_read(8'h03, 0, "R8 watchdog 63");
    wdog_count = 10'd64;   run_read(8'h03, 0, "R8 watchdog 64 clamps");
    wdog_count = 10'd1023; run_read(8'h03, 0, "R8 watchdog 1023 clamps");

    run_read(8'h00, 0, "R6 capabilities 00");
    run_read(8'h02, 0, "R6 command 02");
    run_read(8'hA5, 0, "R6 command A5");

    power_state = 3'b101;
    run_read(8'h01, 1, "R9 captured before input change");

    // R3: wrong address, then ignored until start
    bus_start();
    put_byte({own_addr ^ 7'h01, 1'b0}, k);
    check(!k, "R3 wrong address no ack", k, 0);
    put_byte({own_addr, 1'b0}, k);
    check(!k, "R3 ignored until start", k, 0);
    bus_stop();
    // R3: read bit in first phase
    bus_start();
    put_byte({own_addr, 1'b1}, k);
    check(!k, "R3 read bit in first phase", k, 0);
    bus_stop();
    // R3: write bit in second phase
    bus_start();
    put_byte({own_addr, 1'b0}, k);
    put_byte(8'h01, k);
    bus_start();
    put_byte({own_addr, 1'b0}, k);
    check(!k, "R3 write bit in second phase", k, 0);
    bus_stop();

    // R10: start in the middle of the address byte
    power_state = 3'b011;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    run_read(8'h01, 0, "R10 start mid address");
    // R10: start in the middle of the command byte
    bus_start();
    put_byte({own_addr, 1'b0}, k);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    wdog_count = 10'd12;
    run_read(8'h03, 0, "R10 start mid command");
    // R10: stop in the middle of a byte
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check(!sda_drive_low, "R10 stop releases", sda_drive_low, 0);
    run_read(8'h01, 0, "R10 read after stop abort");

    check(r5_viol == 0, "R5 SDA moved while SCL high", r5_viol, 0);

    repeat (20) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule